// File: doc/BRIEF.md
# Conversion Result Buffer with Level Trigger

This block is a circular store for 16-bit conversion results, for example touch coordinates arriving as alternating X and Y words. A producer offers one word per cycle with a valid strobe. A host pulls words out through a register-style read strobe, and the word appears on the data output one cycle later. The block keeps a write pointer, a read pointer and a trigger pointer. The trigger pointer always lies a programmed number of words ahead of the read point. When a write brings the write pointer onto the trigger pointer, meaning the stored count has just reached the trigger level, an interrupt is raised. The interrupt stays up until the host has read enough words that the count drops below the level again.

The trigger level is given as a small code and counts single words, not coordinate pairs. A level of 8 therefore fires after four X-Y pairs. A mode input selects continuous collection or one-shot collection. In continuous mode writing carries on after a trigger, and every new upward crossing of the level fires again. In one-shot mode all further writes are refused once the first trigger has fired. Dropping the enable input empties the buffer, returns every pointer to its reset value and clears all flags.

Top module: `conv_result_buffer`

## Requirements
- R1: While `buf_en` is 0, the write pointer and the read pointer are 0, `empty` is 1, `irq`, `full` and `overflow` are 0, `trig_ptr` equals the trigger level modulo 64, and strobes on `wr_valid` or `rd_strobe` change nothing.
- R2: Accepted words are returned in write order. `rd_data` carries the word at the read pointer in the cycle after an accepted `rd_strobe`.
- R3: A `trig_code` value c gives a trigger level of 4*(c+1) words, so the range is 4 to 64. `irq` rises in the cycle after the write that brings the stored count up to the level.
- R4: `trig_ptr` equals the read pointer plus the trigger level, modulo 64, and it follows every read.
- R5: Once raised, `irq` stays at 1 until a read leaves fewer words stored than the trigger level.
- R6: The store holds 64 words. `full` is 1 when 64 words are stored. A write offered while full is dropped without moving the write pointer and sets `overflow`. `overflow` stays at 1 until `buf_en` is taken low.
- R7: With `oneshot_mode`=1, every write after the first trigger is dropped and does not set `overflow`, until the buffer is disabled. With `oneshot_mode`=0, writes continue and each later upward crossing of the level raises `irq` again.
- R8: A read strobe while the buffer is empty is ignored: the read pointer and `rd_data` keep their values.
- R9: A read and a write accepted in the same cycle both advance their pointers and leave the stored count, `full` and `empty` unchanged.
- R10: `empty` is 1 exactly when no word is stored, and `full` and `empty` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_en | input | 1 | Buffer enable; 0 clears the pointers and flags |
| oneshot_mode | input | 1 | 1 = stop after the first trigger, 0 = continuous |
| trig_code | input | 4 | Trigger level code; level = 4*(code+1) |
| wr_valid | input | 1 | Write strobe for a result word |
| wr_data | input | 16 | Result word to store |
| rd_strobe | input | 1 | Read strobe; pops the oldest word |
| rd_data | output | 16 | Word returned by the last accepted read |
| irq | output | 1 | Trigger interrupt, active high |
| full | output | 1 | 64 words stored |
| empty | output | 1 | No word stored |
| overflow | output | 1 | Sticky flag: a write was dropped because the buffer was full |
| wr_ptr | output | 6 | Write pointer |
| rd_ptr | output | 6 | Read pointer |
| trig_ptr | output | 6 | Trigger pointer |

## Verification
The assertions check, on every cycle, the rules that relate one cycle to the next. Disabling clears the pointers. A paired read and write keeps the count. `irq` holds until a read takes place. `overflow` is sticky. A full or stopped buffer, or an empty read, leaves its pointer still. Only the bench scenarios can show that the data comes back in write order, where the trigger fires for two different level codes including the 64-word wrap, that the trigger pointer follows reads, and that the two modes differ after a trigger.

// File: rtl/cbuf_pkg.sv
package cbuf_pkg;

    // Collection mode after a trigger has fired
    typedef enum logic {
        CB_CONTINUOUS = 1'b0,
        CB_ONESHOT    = 1'b1
    } cbuf_mode_e;

    // Per-cycle access decisions made at the top level
    typedef struct packed {
        logic wr_fire;    // write accepted into the store
        logic rd_fire;    // read accepted from the store
        logic wr_ovf;     // write refused because the store is full
    } cbuf_acc_t;

endpackage

// File: rtl/cbuf_mem.sv
module cbuf_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    // Registered read; it sees the old word if the same slot is written now
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= store_q[raddr];
    end
endmodule

// File: rtl/cbuf_ptrs.sv
module cbuf_ptrs #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_fire,
    input  logic          rd_fire,
    output logic [AW-1:0] wp_q,
    output logic [AW-1:0] rp_q,
    output logic [AW-1:0] rp_nxt,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0] wp_nxt;

    always_comb begin
        wp_nxt  = wp_q;
        rp_nxt  = rp_q;
        cnt_nxt = cnt_q;
        if (!en) begin
            wp_nxt  = '0;
            rp_nxt  = '0;
            cnt_nxt = '0;
        end else begin
            if (wr_fire) wp_nxt = wp_q + AW'(1);
            if (rd_fire) rp_nxt = rp_q + AW'(1);
            case ({wr_fire, rd_fire})
                2'b10:   cnt_nxt = cnt_q + CW'(1);
                2'b01:   cnt_nxt = cnt_q - CW'(1);
                default: cnt_nxt = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            wp_q  <= wp_nxt;
            rp_q  <= rp_nxt;
            cnt_q <= cnt_nxt;
        end
    end

    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);

    // R1
    dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (wp_q == '0 && rp_q == '0 && cnt_q == '0));
    // R9
    rw_count_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr_fire && rd_fire) |=> $stable(cnt_q));
endmodule

// File: rtl/cbuf_trig.sv
module cbuf_trig
    import cbuf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  cbuf_mode_e    mode,
    input  logic [CW-1:0] level,
    input  logic          wr_fire,
    input  logic          rd_fire,
    input  logic [CW-1:0] cnt_nxt,
    input  logic [AW-1:0] rp_nxt,
    output logic [AW-1:0] tp_q,
    output logic          irq_q,
    output logic          stop_q
);
    logic hit;

    // The write pointer lands on the trigger pointer exactly when the count rises to the level
    assign hit = en && wr_fire && !rd_fire && (cnt_nxt == level);

    always_ff @(posedge clk) begin
        if (rst) begin
            tp_q   <= level[AW-1:0];
            irq_q  <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            tp_q <= rp_nxt + level[AW-1:0];
            if (!en) begin
                irq_q  <= 1'b0;
                stop_q <= 1'b0;
            end else begin
                if (hit)
                    irq_q <= 1'b1;
                else if (rd_fire && (cnt_nxt < level))
                    irq_q <= 1'b0;
                if (hit && mode == CB_ONESHOT)
                    stop_q <= 1'b1;
            end
        end
    end

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && irq_q && !rd_fire) |=> irq_q);
    // R3
    trig_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (en && wr_fire && !rd_fire && cnt_nxt == level) |=> irq_q);
endmodule

// File: rtl/conv_result_buffer.sv
module conv_result_buffer
    import cbuf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int STEP   = 4,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1,
    localparam int LW    = $clog2(DEPTH / STEP)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_en,
    input  logic              oneshot_mode,
    input  logic [LW-1:0]     trig_code,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              full,
    output logic              empty,
    output logic              overflow,
    output logic [AW-1:0]     wr_ptr,
    output logic [AW-1:0]     rd_ptr,
    output logic [AW-1:0]     trig_ptr
);
    cbuf_acc_t     acc;
    cbuf_mode_e    mode;
    logic [CW-1:0] level;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic [AW-1:0] rp_nxt;
    logic          stopped;
    logic          ovf_q;

    assign mode  = cbuf_mode_e'(oneshot_mode);
    assign level = (CW'(trig_code) + CW'(1)) * CW'(STEP);

    always_comb begin
        acc.rd_fire = buf_en && rd_strobe && !empty;
        acc.wr_fire = buf_en && wr_valid && !stopped && (!full || acc.rd_fire);
        acc.wr_ovf  = buf_en && wr_valid && !stopped && full && !acc.rd_fire;
    end

    cbuf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (acc.wr_fire),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .re    (acc.rd_fire),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    cbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .en      (buf_en),
        .wr_fire (acc.wr_fire),
        .rd_fire (acc.rd_fire),
        .wp_q    (wr_ptr),
        .rp_q    (rd_ptr),
        .rp_nxt  (rp_nxt),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .full    (full),
        .empty   (empty)
    );

    cbuf_trig #(.DEPTH(DEPTH)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .en      (buf_en),
        .mode    (mode),
        .level   (level),
        .wr_fire (acc.wr_fire),
        .rd_fire (acc.rd_fire),
        .cnt_nxt (cnt_nxt),
        .rp_nxt  (rp_nxt),
        .tp_q    (trig_ptr),
        .irq_q   (irq),
        .stop_q  (stopped)
    );

    always_ff @(posedge clk) begin
        if (rst || !buf_en) ovf_q <= 1'b0;
        else if (acc.wr_ovf) ovf_q <= 1'b1;
    end
    assign overflow = ovf_q;

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en && overflow) |=> overflow);
    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en && full && wr_valid && !rd_strobe) |=> $stable(wr_ptr));
    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en && stopped) |=> $stable(wr_ptr));
    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_en && empty && rd_strobe) |=> ($stable(rd_ptr) && $stable(rd_data)));
    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({full, empty}));
endmodule

// File: tb/tb_conv_result_buffer.sv
`timescale 1ns/1ps
module tb_conv_result_buffer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        buf_en = 1'b0;
    logic        oneshot_mode = 1'b0;
    logic [3:0]  trig_code = 4'd1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_strobe = 1'b0;
    logic [15:0] rd_data;
    logic        irq, full, empty, overflow;
    logic [5:0]  wr_ptr, rd_ptr, trig_ptr;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    logic [15:0] exp_q[$];

    always #2 clk = ~clk;

    conv_result_buffer dut (
        .clk(clk), .rst(rst), .buf_en(buf_en), .oneshot_mode(oneshot_mode),
        .trig_code(trig_code), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq), .full(full),
        .empty(empty), .overflow(overflow), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .trig_ptr(trig_ptr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: offers one cycle of stimulus, pushes accepted words to the scoreboard;
    // monitor part: compares the returned word with the popped expectation.
    task automatic step(input bit wv, input logic [15:0] wd, input bit acc,
                        input bit rs, input bit pop, input string tag);
        logic [15:0] e = '0;
        wr_valid  = wv;
        wr_data   = wd;
        rd_strobe = rs;
        if (wv && acc) exp_q.push_back(wd);
        if (rs && pop) e = exp_q.pop_front();
        @(negedge clk);
        wr_valid  = 1'b0;
        rd_strobe = 1'b0;
        if (rs && pop) chk(tag, rd_data, e);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R10 reset state, level code 1 -> 8
        chk("R1 empty after reset", empty, 1);
        chk("R10 full after reset", full, 0);
        chk("R1 irq after reset", irq, 0);
        chk("R1 wr_ptr after reset", wr_ptr, 0);
        chk("R1 trig_ptr at level 8", trig_ptr, 8);

        // R3 continuous, level 8
        buf_en = 1'b1;
        for (int i = 0; i < 7; i++) step(1, 16'hA000 + 16'(i), 1, 0, 0, "");
        chk("R3 no irq at 7 words", irq, 0);
        chk("R3 wr_ptr at 7", wr_ptr, 7);
        step(1, 16'hA007, 1, 0, 0, "");
        chk("R3 irq at 8 words", irq, 1);
        step(1, 16'hA008, 1, 0, 0, "");
        step(1, 16'hA009, 1, 0, 0, "");
        // R5 hold while count stays at or above level
        step(0, 0, 0, 1, 1, "R2 data order 0");
        chk("R5 irq held at 9", irq, 1);
        chk("R4 trig_ptr follows read", trig_ptr, 9);
        step(0, 0, 0, 1, 1, "R2 data order 1");
        chk("R5 irq held at 8", irq, 1);
        step(0, 0, 0, 1, 1, "R2 data order 2");
        chk("R5 irq cleared at 7", irq, 0);
        chk("R4 trig_ptr rp3+8", trig_ptr, 11);
        // R9 simultaneous read and write
        step(1, 16'hA00A, 1, 1, 1, "R9 data on paired read");
        chk("R9 wr_ptr advanced", wr_ptr, 11);
        chk("R9 rd_ptr advanced", rd_ptr, 4);
        chk("R9 count kept irq low", irq, 0);
        chk("R9 not empty", empty, 0);
        // R7 continuous re-trigger
        step(1, 16'hA00B, 1, 0, 0, "");
        chk("R7 continuous re-trigger", irq, 1);
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, "R2 drain order");
        chk("R10 empty after drain", empty, 1);
        chk("R2 rd_ptr after drain", rd_ptr, 12);
        // R8 empty read ignored
        step(0, 0, 0, 1, 0, "");
        chk("R8 rd_ptr kept", rd_ptr, 12);
        chk("R8 rd_data kept", rd_data, 16'hA00B);

        // R1 disable
        buf_en = 1'b0;
        exp_q.delete();
        step(0, 0, 0, 0, 0, "");
        chk("R1 wr_ptr cleared", wr_ptr, 0);
        chk("R1 rd_ptr cleared", rd_ptr, 0);
        chk("R1 trig_ptr level 8", trig_ptr, 8);
        trig_code = 4'd15;
        step(1, 16'h1111, 0, 1, 0, "");
        chk("R1 trig_ptr level 64 wraps", trig_ptr, 0);
        chk("R1 write ignored when off", wr_ptr, 0);
        chk("R1 still empty", empty, 1);

        // R6 level 64, fill and overflow
        buf_en = 1'b1;
        for (int i = 0; i < 63; i++) step(1, 16'hB000 + 16'(i), 1, 0, 0, "");
        chk("R3 no irq at 63", irq, 0);
        chk("R6 not full at 63", full, 0);
        step(1, 16'hB03F, 1, 0, 0, "");
        chk("R3 irq at 64", irq, 1);
        chk("R6 full at 64", full, 1);
        chk("R6 overflow clear before drop", overflow, 0);
        step(1, 16'hDEAD, 0, 0, 0, "");
        chk("R6 dropped write keeps wr_ptr", wr_ptr, 0);
        chk("R6 overflow set", overflow, 1);
        step(0, 0, 0, 1, 1, "R6 first word survives");
        chk("R6 overflow sticky", overflow, 1);
        chk("R5 irq drops below 64", irq, 0);
        buf_en = 1'b0;
        exp_q.delete();
        step(0, 0, 0, 0, 0, "");
        chk("R6 overflow cleared by disable", overflow, 0);

        // R7 one-shot, level 4
        trig_code = 4'd0;
        oneshot_mode = 1'b1;
        buf_en = 1'b1;
        for (int i = 0; i < 4; i++) step(1, 16'hC000 + 16'(i), 1, 0, 0, "");
        chk("R3 irq at level 4", irq, 1);
        step(1, 16'hC004, 0, 0, 0, "");
        step(1, 16'hC005, 0, 0, 0, "");
        chk("R7 one-shot stops writes", wr_ptr, 4);
        chk("R7 no overflow when stopped", overflow, 0);
        step(0, 0, 0, 1, 1, "R7 one-shot data 0");
        chk("R5 irq cleared at 3", irq, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 1, "R7 one-shot data");
        step(1, 16'hC006, 0, 0, 0, "");
        chk("R7 still stopped", wr_ptr, 4);
        chk("R7 empty while stopped", empty, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule